// File: doc/BRIEF.md
# Microstep Excitation Sequencer

This block tracks the electrical position of a two-phase bipolar stepper motor and turns it into two signed current setpoints, one per phase, expressed in percent of full current. Each rising edge on an asynchronous step input moves the position one step forward or backward. The step size is chosen by a two-bit resolution code, from full steps down to eighth steps. All resolutions read magnitudes from one shared quarter-sine table. A two-bit torque code then scales the looked-up magnitude.

The active-low reset parks the sequencer in a defined home position, which depends on the resolution. An active-low home flag reports whenever the position equals that home point. The output-enable input only blanks the setpoint words. The position keeps moving while the outputs are blank, so the setpoints come back from the current position when enable returns. A one-cycle strobe marks each accepted step for the downstream chopper. Sensing, chopping and bridge drive are handled elsewhere.

Top module: `stepper_seq`

## Requirements
- R1: The resolution code `mode` sets the stride in a 32-unit electrical cycle. 00 is full step with stride 8. 01 is half step with stride 4. 10 is quarter step with stride 2. 11 is eighth step with stride 1. The position wraps modulo 32.
- R2: For position p (0..31), phase A magnitude is T[f(p)] and phase B magnitude is T[f((p+24) mod 32)].
  - The table is T[0..8] = 100, 98, 92, 83, 71, 56, 38, 20, 0.
  - f(p) is r when r ≤ 8 and 16−r otherwise, where r = p mod 16.
  - A phase sign bit is 1 (negative) when its effective position lies in 9..23.
- R3: In full-step mode (00) both phase magnitudes are 100 before torque scaling, whatever the position. The signs still follow R2.
- R4: While `rst_n` is low, the sequencer holds its home position and step edges are ignored. The home position is 4 in mode 00 and 0 in every other mode. So with full torque, A is +100, and B is +100 in mode 00 and 0 in the other modes. A change of `mode` during reset is seen at once.
- R5: `at_home_n` is 0 exactly when the current position equals the home position of the current mode, and 1 otherwise. This holds regardless of `out_en`.
- R6: The first step after reset release moves from the home position of the current mode by one stride, in the selected direction.
- R7: With `dir_rev` = 0 the position increases by the stride on each step. With `dir_rev` = 1 it decreases by the stride.
- R8: While `out_en` is 0, both magnitudes and both sign bits are 0, but steps still move the position. When `out_en` returns to 1, the outputs show the moved position.
- R9: The torque code scales each magnitude m to floor(m·k/100). The code 00 gives k = 100, 01 gives k = 75, 10 gives k = 50 and 11 gives k = 20.
- R10: Each rising edge of `step_clk` outside reset produces exactly one `step_evt` pulse, one clock wide. The position changes only on the clock edge at which `step_evt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; holds the home position |
| step_clk | input | 1 | Asynchronous step input, rising edge steps |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| mode | input | 2 | Resolution code |
| torque | input | 2 | Torque scaling code |
| out_en | input | 1 | 1 drives setpoints, 0 blanks them |
| a_neg | output | 1 | Phase A sign, 1 = negative |
| a_mag | output | 7 | Phase A magnitude in percent |
| b_neg | output | 1 | Phase B sign, 1 = negative |
| b_mag | output | 7 | Phase B magnitude in percent |
| at_home_n | output | 1 | Low while at the home position |
| step_evt | output | 1 | One-cycle strobe per accepted step |

## Verification
Two things can happen in the same cycle: a step that moves the position, and blanking by `out_en` or a change of `mode`. The bench provokes this by sending several step edges while enable is low and then raising enable. It judges the result by whether the restored setpoints match a reference position advanced by every blanked step. A second case sends step edges while reset is low and changes the mode in the same window. The bench then checks that the home point follows the new mode, that no strobe appears, and that the first step after release leaves from the new home point.

// File: rtl/stepseq_pkg.sv
`timescale 1ns/1ps
package stepseq_pkg;

  localparam int POS_W   = 5;
  localparam int MAG_W   = 7;
  localparam int MODE_W  = 2;
  localparam int TRQ_W   = 2;
  localparam int PROD_W  = 2 * MAG_W;
  localparam int CYCLE   = 1 << POS_W;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [MAG_W-1:0]  mag_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [TRQ_W-1:0]  trq_t;

  // stride in eighth-step units: full=8, half=4, quarter=2, eighth=1
  function automatic pos_t mode_stride(input mode_t m);
    pos_t base;
    base = pos_t'(8);
    return base >> m;
  endfunction

  // home point: full-step sits between the axes so both phases are driven
  function automatic pos_t home_pos(input mode_t m);
    return (m == 2'b00) ? pos_t'(4) : pos_t'(0);
  endfunction

  // quarter-sine magnitude, index 0..8
  function automatic mag_t qsine(input logic [3:0] idx);
    mag_t v;
    case (idx)
      4'd0:    v = 7'd100;
      4'd1:    v = 7'd98;
      4'd2:    v = 7'd92;
      4'd3:    v = 7'd83;
      4'd4:    v = 7'd71;
      4'd5:    v = 7'd56;
      4'd6:    v = 7'd38;
      4'd7:    v = 7'd20;
      default: v = 7'd0;
    endcase
    return v;
  endfunction

  // fold a position within a half cycle onto the 0..8 table index
  function automatic logic [3:0] fold_idx(input pos_t p);
    logic [3:0] r;
    r = p[3:0];
    return (r <= 4'd8) ? r : (4'd0 - r);
  endfunction

  // cosine-shaped sign: negative strictly inside the second and third quarter
  function automatic logic neg_of(input pos_t p);
    return (p > pos_t'(8)) && (p < pos_t'(24));
  endfunction

  function automatic mag_t torque_pct(input trq_t t);
    mag_t k;
    case (t)
      2'b00:   k = 7'd100;
      2'b01:   k = 7'd75;
      2'b10:   k = 7'd50;
      default: k = 7'd20;
    endcase
    return k;
  endfunction

  function automatic mag_t scale_mag(input mag_t m, input trq_t t);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    prod = PROD_W'(m) * PROD_W'(torque_pct(t));
    quo  = prod / PROD_W'(100);
    return quo[MAG_W-1:0];
  endfunction

endpackage

// File: rtl/step_sync.sv
`timescale 1ns/1ps
module step_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_async,
  output logic step_pulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= step_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign step_pulse = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse); // R10

endmodule

// File: rtl/phase_pos.sv
`timescale 1ns/1ps
module phase_pos
  import stepseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  dir_rev,
  input  mode_t mode,
  output pos_t  pos_eff,
  output logic  at_home
);
  logic home_q;
  pos_t pos_q;
  pos_t base;
  pos_t stride;
  pos_t pos_nxt;

  always_comb begin
    base    = home_q ? home_pos(mode) : pos_q;
    stride  = mode_stride(mode);
    pos_nxt = dir_rev ? (base - stride) : (base + stride);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home_q <= 1'b1;
      pos_q  <= '0;
    end else if (step) begin
      home_q <= 1'b0;
      pos_q  <= pos_nxt;
    end
  end

  assign pos_eff = base;
  assign at_home = (base == home_pos(mode));

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q) && $stable(home_q)); // R10

  AST_LEAVE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !home_q); // R6

endmodule

// File: rtl/phase_map.sv
`timescale 1ns/1ps
module phase_map
  import stepseq_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  pos_t  pos,
  input  mode_t mode,
  input  trq_t  torque,
  input  logic  en,
  output logic  neg,
  output mag_t  mag
);
  localparam pos_t OFS = pos_t'(OFFSET);

  pos_t ph;
  mag_t raw;

  always_comb begin
    ph  = pos + OFS;
    raw = (mode == 2'b00) ? mag_t'(100) : qsine(fold_idx(ph));
    neg = en & neg_of(ph);
    mag = en ? scale_mag(raw, torque) : '0;
  end

endmodule

// File: rtl/stepper_seq.sv
`timescale 1ns/1ps
module stepper_seq
  import stepseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_clk,
  input  logic       dir_rev,
  input  logic [1:0] mode,
  input  logic [1:0] torque,
  input  logic       out_en,
  output logic       a_neg,
  output logic [6:0] a_mag,
  output logic       b_neg,
  output logic [6:0] b_mag,
  output logic       at_home_n,
  output logic       step_evt
);
  localparam int NPH = 2;

  logic step_pulse;
  pos_t pos_eff;
  logic at_home;
  logic [NPH-1:0] ph_neg;
  mag_t           ph_mag [NPH];

  step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .step_async(step_clk), .step_pulse(step_pulse)
  );

  phase_pos u_pos (
    .clk(clk), .rst_n(rst_n), .step(step_pulse), .dir_rev(dir_rev),
    .mode(mode), .pos_eff(pos_eff), .at_home(at_home)
  );

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_phase
      // phase B trails phase A by a quarter cycle
      phase_map #(.OFFSET((g == 0) ? 0 : 24)) u_map (
        .pos(pos_eff), .mode(mode), .torque(torque), .en(out_en),
        .neg(ph_neg[g]), .mag(ph_mag[g])
      );
    end
  endgenerate

  assign a_neg     = ph_neg[0];
  assign a_mag     = ph_mag[0];
  assign b_neg     = ph_neg[1];
  assign b_mag     = ph_mag[1];
  assign at_home_n = ~at_home;
  assign step_evt  = step_pulse;

  AST_TWOPHASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode == 2'b00 && torque == 2'b00 |-> a_mag == 7'd100 && b_mag == 7'd100); // R3

  AST_HOME_A_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !at_home_n && out_en && torque == 2'b00 |-> a_mag == 7'd100 && !a_neg); // R5

endmodule

// File: tb/sim_stepper_seq.sv
`timescale 1ns/1ps
module sim_stepper_seq;

  typedef struct {
    logic       an;
    logic [6:0] am;
    logic       bn;
    logic [6:0] bm;
    logic       hn;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, step_clk, dir_rev, out_en;
  logic [1:0] mode, torque;
  logic a_neg, b_neg, at_home_n, step_evt;
  logic [6:0] a_mag, b_mag;

  int n_tests = 0;
  int n_fail  = 0;
  int evt_cnt = 0;
  int pulses  = 0;
  bit done    = 1'b0;

  int  m_pos  = 0;
  bit  m_home = 1'b1;
  int  lut [9] = '{100, 98, 92, 83, 71, 56, 38, 20, 0};
  exp_t q[$];

  always #2 clk = ~clk;

  stepper_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .dir_rev(dir_rev),
    .mode(mode), .torque(torque), .out_en(out_en),
    .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg), .b_mag(b_mag),
    .at_home_n(at_home_n), .step_evt(step_evt)
  );

  always @(negedge clk) if (step_evt) evt_cnt++;

  function automatic int home_of(input logic [1:0] m);
    return (m == 2'b00) ? 4 : 0;
  endfunction

  function automatic int cur_pos();
    return m_home ? home_of(mode) : m_pos;
  endfunction

  function automatic int sine_of(input int p);
    int x;
    x = p % 32;
    if (x <= 8)       return lut[x];
    else if (x <= 16) return lut[16 - x];
    else if (x <= 24) return lut[x - 16];
    else              return lut[32 - x];
  endfunction

  function automatic int pct_of(input logic [1:0] t);
    case (t)
      2'b00: return 100;
      2'b01: return 75;
      2'b10: return 50;
      default: return 20;
    endcase
  endfunction

  function automatic int mag_exp(input int p);
    int raw;
    raw = (mode == 2'b00) ? 100 : sine_of(p);
    return out_en ? (raw * pct_of(torque)) / 100 : 0;
  endfunction

  function automatic logic neg_exp(input int p);
    int x;
    x = p % 32;
    return out_en && (x > 8) && (x < 24);
  endfunction

  task automatic push(input string tag);
    exp_t e;
    int p;
    p = cur_pos();
    e.an  = neg_exp(p);
    e.am  = 7'(mag_exp(p));
    e.bn  = neg_exp(p + 24);
    e.bm  = 7'(mag_exp(p + 24));
    e.hn  = (p == home_of(mode)) ? 1'b0 : 1'b1;
    e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic pulse_step();
    @(posedge clk); #1 step_clk = 1'b1;
    repeat (4) @(posedge clk);
    #1 step_clk = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    if (rst_n) begin
      int s;
      s = 8 >> mode;
      m_pos  = (cur_pos() + (dir_rev ? 32 - s : s)) % 32;
      m_home = 1'b0;
      pulses++;
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        n_tests++;
        if (a_neg !== e.an || a_mag !== e.am || b_neg !== e.bn ||
            b_mag !== e.bm || at_home_n !== e.hn) begin
          n_fail++;
          $display("FAIL %s actual A=%0b/%0d B=%0b/%0d home_n=%0b expected A=%0b/%0d B=%0b/%0d home_n=%0b",
                   e.tag, a_neg, a_mag, b_neg, b_mag, at_home_n,
                   e.an, e.am, e.bn, e.bm, e.hn);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int ev0;
    rst_n = 1'b0; step_clk = 1'b0; dir_rev = 1'b0;
    mode = 2'b01; torque = 2'b00; out_en = 1'b1;
    repeat (5) @(posedge clk); #1;
    push("R4 reset home, half step");
    mode = 2'b00;
    push("R4 R3 reset home, full step");
    ev0 = evt_cnt;
    mode = 2'b10;
    pulse_step();
    pulse_step();
    push("R4 steps ignored in reset");
    check_int("R10 no strobe in reset", evt_cnt - ev0, 0);
    mode = 2'b11;
    push("R5 home flag follows mode in reset");

    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < 32; i++) begin
      pulse_step();
      push(i == 0 ? "R6 first step after release" : "R2 eighth step table");
    end
    push("R5 home after full cycle");

    mode = 2'b10;
    for (int i = 0; i < 3; i++) begin
      pulse_step();
      push("R1 quarter step stride");
    end
    mode = 2'b01;
    pulse_step();
    push("R1 half step stride");

    dir_rev = 1'b1;
    mode = 2'b11;
    for (int i = 0; i < 12; i++) begin
      pulse_step();
      push("R7 reverse with wrap");
    end
    dir_rev = 1'b0;

    mode = 2'b00;
    for (int i = 0; i < 4; i++) begin
      pulse_step();
      push("R3 full step magnitudes");
    end

    mode = 2'b11;
    out_en = 1'b0;
    push("R8 blanked outputs");
    for (int i = 0; i < 3; i++) begin
      pulse_step();
      push("R8 blanked while stepping");
    end
    out_en = 1'b1;
    push("R8 resume at moved position");

    pulse_step();
    for (int t = 1; t < 4; t++) begin
      torque = 2'(t);
      push("R9 torque scaling");
    end
    mode = 2'b00;
    torque = 2'b01;
    push("R9 torque on full step");
    torque = 2'b00;

    check_int("R10 one strobe per step", evt_cnt, pulses);

    rst_n = 1'b0;
    m_home = 1'b1;
    mode = 2'b10;
    repeat (3) @(posedge clk); #1;
    push("R4 re-reset home");
    rst_n = 1'b1;
    dir_rev = 1'b1;
    repeat (3) @(posedge clk); #1;
    pulse_step();
    push("R6 R7 reverse first step from home");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule